// File: doc/BRIEF.md
# I2C Real-Time-Clock Transaction Monitor

This block watches an I2C bus from the side and never drives it. The event stream it receives is already decoded: one bus event per cycle, marked by a valid strobe. Each event has a type code, a byte and an acknowledge bit. The block follows the register accesses that a bus master makes to a real-time-clock device at bus address 0xA2 (write) / 0xA3 (read). It does this with a six-state transaction machine. The machine splits a plain register write from a pointer-set-then-read sequence at the repeated start.

A register pointer is loaded from the first data byte after the device address, and it steps after every acknowledged data byte. Each byte is decoded according to the register it lands on. The six time-of-day and calendar fields are masked, converted from BCD to binary and latched. The supply-low flag and five control/status flags are latched as well.

At the stop that closes a transaction, the block pulses a record strobe for one cycle. The record carries a read/write flag, all latched values, and a per-field valid mask, so that transactions touching only some registers can be told apart.

Top module: `rtc_xact_monitor`

## Requirements
- R1: After reset, recValid is 0, recFieldValid is 0 and every time field output reads the invalid marker 0xFF.
- R2: Event codes are START=0, RSTART=1, ADDR_WR=2, ADDR_RD=3, DATA_WR=4, DATA_RD=5, STOP=6. While idle, only START is acted on; any other event in idle produces no record and no field change.
- R3: After START, an ADDR_WR event with byte 0xA2 is required, and the next DATA_WR loads the register pointer from the byte's low four bits. In any non-idle state, an address event whose byte does not equal 0xA2 (for ADDR_WR) or 0xA3 (for ADDR_RD) returns the machine to idle without a record.
- R4: A STOP in the write phase or in the read-data phase raises recValid for exactly one cycle, in the cycle after the STOP event is accepted. recIsRead is 0 for the write phase and 1 for the read phase.
- R5: Field values are binary conversions (low nibble + 10 × high nibble) of the masked byte. Seconds (register 2) and minutes (3) use mask 0x7F, hours (4) and day (5) use 0x3F, month (7) uses 0x1F and year (8) uses all 8 bits. recFieldValid bit order is sec, min, hour, day, month, year from bit 0.
- R6: Bit 7 of a byte applied to register 2 is reported on recVoltLow and never appears in the seconds value.
- R7: Bits [4:0] of a byte applied to register 1 are reported on recCtrl at the same bit positions: repeat-timer mode, alarm flag, timer flag, alarm interrupt enable, timer interrupt enable.
- R8: Each START accepted from idle resets all time fields to 0xFF with their valid bits cleared, and resets recVoltLow and recCtrl to 0. Fields not written in a transaction stay invalid in its record.
- R9: The pointer increments by one after each acknowledged applied byte and wraps from 0xF to 0x0. Bytes at registers 0, 6 and 9 to 15 advance the pointer but change no output.
- R10: A data byte with ack 0 is still applied, but the pointer does not advance, and every later data byte in the same transaction is ignored.
- R11: In the write phase, RSTART moves to the read-address phase. ADDR_RD with 0xA3 then enters the read-data phase, where DATA_RD bytes are applied. DATA_RD in the write phase and DATA_WR in the read-data phase are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | An event is present this cycle |
| evType | input | 3 | Event type code (see R2) |
| evByte | input | 8 | Address or data byte of the event |
| evAck | input | 1 | 1 = byte acknowledged, 0 = NACK |
| recValid | output | 1 | One-cycle record strobe |
| recIsRead | output | 1 | Record came from the read path |
| recSec | output | 8 | Seconds, binary |
| recMin | output | 8 | Minutes, binary |
| recHour | output | 8 | Hours, binary |
| recDay | output | 8 | Day of month, binary |
| recMonth | output | 8 | Month, binary |
| recYear | output | 8 | Year, binary |
| recFieldValid | output | 6 | Per-field valid mask |
| recVoltLow | output | 1 | Supply-low flag |
| recCtrl | output | 5 | Control/status flags |

## Verification
The bench targets four corner cases, and each has a distinct failure signature:
- **Pointer wrap from 0xF to 0x0.** A design that saturates or widens the pointer would drop the control and seconds bytes that follow the wrap.
- **NACK mid-burst.** A design that keeps stepping, or keeps applying bytes on a frozen pointer, would overwrite or fill the next field.
- **Mismatched device address, and a direction-mismatched data event.** A design that ignores either would emit spurious records or wrong fields.
- **Bit 7 of the seconds byte.** It must reach the supply-low flag, and a missing mask would inflate the seconds value by 80.

Randomized write and read transactions then cross-check all record fields against a bench model.

// File: rtl/rtc_mon_pkg.sv
package rtc_mon_pkg;
  localparam int DATA_W     = 8;
  localparam int PTR_W      = 4;
  localparam int NUM_FIELDS = 6;
  localparam int CTRL_W     = 5;
  localparam logic [DATA_W-1:0] INVALID_MARK = '1;
  localparam logic [PTR_W-1:0]  REG_CTRL = 4'd1;
  localparam logic [PTR_W-1:0]  REG_SEC  = 4'd2;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RSTART  = 3'd1,
    EV_ADDR_WR = 3'd2,
    EV_ADDR_RD = 3'd3,
    EV_DATA_WR = 3'd4,
    EV_DATA_RD = 3'd5,
    EV_STOP    = 3'd6
  } evType_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_DEV, ST_WAIT_REG, ST_WR_REGS, ST_RD_ADDR, ST_RD_DATA
  } monState_e;

  typedef struct packed {
    logic clrFields;
    logic loadPtr;
    logic applyByte;
    logic emitRec;
    logic recIsRead;
  } ctrlStrb_t;

  function automatic logic [PTR_W-1:0] fieldAddr(int idx);
    case (idx)
      0: return 4'd2;
      1: return 4'd3;
      2: return 4'd4;
      3: return 4'd5;
      4: return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fieldMask(int idx);
    case (idx)
      0, 1: return 8'h7F;
      2, 3: return 8'h3F;
      4: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bcdToBin(logic [DATA_W-1:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction
endpackage

// File: rtl/rtc_mon_ctrl.sv
module rtc_mon_ctrl
  import rtc_mon_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEV_ADDR = 8'hA2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [2:0]        evType,
  input  logic [DATA_W-1:0] evByte,
  output ctrlStrb_t         strb
);
  localparam logic [DATA_W-1:0] ADDR_WR_BYTE = DEV_ADDR & 8'hFE;
  localparam logic [DATA_W-1:0] ADDR_RD_BYTE = DEV_ADDR | 8'h01;

  monState_e state, nxt;
  evType_e   ev;
  logic      isAddr, devMatch;

  assign ev       = evType_e'(evType);
  assign isAddr   = (ev == EV_ADDR_WR) || (ev == EV_ADDR_RD);
  assign devMatch = ((ev == EV_ADDR_WR) && (evByte == ADDR_WR_BYTE)) ||
                    ((ev == EV_ADDR_RD) && (evByte == ADDR_RD_BYTE));

  always_comb begin
    nxt  = state;
    strb = '0;
    if (evValid) begin
      if (isAddr && !devMatch && state != ST_IDLE) begin
        nxt = ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (ev == EV_START) begin
            nxt = ST_WAIT_DEV;
            strb.clrFields = 1'b1;
          end
          ST_WAIT_DEV: if (ev == EV_ADDR_WR) nxt = ST_WAIT_REG;
          ST_WAIT_REG: if (ev == EV_DATA_WR) begin
            nxt = ST_WR_REGS;
            strb.loadPtr = 1'b1;
          end
          ST_WR_REGS: begin
            if (ev == EV_RSTART) nxt = ST_RD_ADDR;
            else if (ev == EV_DATA_WR) strb.applyByte = 1'b1;
            else if (ev == EV_STOP) begin
              nxt = ST_IDLE;
              strb.emitRec = 1'b1;
            end
          end
          ST_RD_ADDR: if (ev == EV_ADDR_RD) nxt = ST_RD_DATA;
          ST_RD_DATA: begin
            if (ev == EV_DATA_RD) strb.applyByte = 1'b1;
            else if (ev == EV_STOP) begin
              nxt = ST_IDLE;
              strb.emitRec   = 1'b1;
              strb.recIsRead = 1'b1;
            end
          end
          default: nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  // R2: idle is left only on a start event
  p_idle_needs_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(evValid && ev == EV_START)) |=> state == ST_IDLE);

  // R11: a repeated start in the write phase leads to the read-address phase
  p_rstart_to_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_REGS && evValid && ev == EV_RSTART) |=> state == ST_RD_ADDR);
endmodule

// File: rtl/rtc_mon_dp.sv
module rtc_mon_dp
  import rtc_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] evByte,
  input  logic              evAck,
  output logic [DATA_W-1:0] fieldVal [NUM_FIELDS],
  output logic [NUM_FIELDS-1:0] fieldValid,
  output logic              voltLow,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic              recValid,
  output logic              recIsRead
);
  logic [PTR_W-1:0] ptr;
  logic             halted;
  logic             doApply;

  assign doApply = strb.applyByte && !halted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      halted <= 1'b0;
    end else if (strb.clrFields) begin
      ptr    <= '0;
      halted <= 1'b0;
    end else if (strb.loadPtr) begin
      ptr    <= evByte[PTR_W-1:0];
      halted <= 1'b0;
    end else if (doApply) begin
      if (evAck) ptr <= ptr + 1'b1;
      else       halted <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    localparam logic [PTR_W-1:0]  F_ADDR = fieldAddr(g);
    localparam logic [DATA_W-1:0] F_MASK = fieldMask(g);
    always_ff @(posedge clk) begin
      if (!rstN || strb.clrFields) begin
        fieldVal[g]   <= INVALID_MARK;
        fieldValid[g] <= 1'b0;
      end else if (doApply && ptr == F_ADDR) begin
        fieldVal[g]   <= bcdToBin(evByte & F_MASK);
        fieldValid[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrFields) begin
      voltLow  <= 1'b0;
      ctrlBits <= '0;
    end else if (doApply) begin
      if (ptr == REG_SEC)  voltLow  <= evByte[DATA_W-1];
      if (ptr == REG_CTRL) ctrlBits <= evByte[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recValid  <= 1'b0;
      recIsRead <= 1'b0;
    end else begin
      recValid <= strb.emitRec;
      if (strb.emitRec) recIsRead <= strb.recIsRead;
    end
  end

  // R8: a transaction start leaves every field invalid
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFields |=> fieldValid == '0);

  // R10: after a NACK the pointer holds until a new pointer load or start
  p_nack_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !strb.clrFields && !strb.loadPtr) |=> $stable(ptr));
endmodule

// File: rtl/rtc_xact_monitor.sv
module rtc_xact_monitor
  import rtc_mon_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hA2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic [2:0] evType,
  input  logic [7:0] evByte,
  input  logic       evAck,
  output logic       recValid,
  output logic       recIsRead,
  output logic [7:0] recSec,
  output logic [7:0] recMin,
  output logic [7:0] recHour,
  output logic [7:0] recDay,
  output logic [7:0] recMonth,
  output logic [7:0] recYear,
  output logic [5:0] recFieldValid,
  output logic       recVoltLow,
  output logic [4:0] recCtrl
);
  ctrlStrb_t         strb;
  logic [DATA_W-1:0] fieldVal [NUM_FIELDS];

  rtc_mon_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType),
    .evByte(evByte), .strb(strb)
  );

  rtc_mon_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .evByte(evByte), .evAck(evAck),
    .fieldVal(fieldVal), .fieldValid(recFieldValid), .voltLow(recVoltLow),
    .ctrlBits(recCtrl), .recValid(recValid), .recIsRead(recIsRead)
  );

  assign recSec   = fieldVal[0];
  assign recMin   = fieldVal[1];
  assign recHour  = fieldVal[2];
  assign recDay   = fieldVal[3];
  assign recMonth = fieldVal[4];
  assign recYear  = fieldVal[5];

  // R4: a record follows an accepted stop and lasts one cycle
  p_rec_after_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> $past(evValid && evType == 3'd6));
  p_rec_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);
endmodule

// File: tb/sim_rtc_xact_monitor.sv
module sim_rtc_xact_monitor;
  localparam int CLK_P = 10;
  localparam int SEED  = 1234;

  logic clk = 0, rstN = 0, evValid = 0, evAck = 1;
  logic [2:0] evType = 0;
  logic [7:0] evByte = 0;
  logic recValid, recIsRead, recVoltLow;
  logic [7:0] recSec, recMin, recHour, recDay, recMonth, recYear;
  logic [5:0] recFieldValid;
  logic [4:0] recCtrl;

  int nTests = 0, nFail = 0;

  // bench model
  logic [7:0] mFld [6];
  logic [5:0] mVld;
  logic       mVl;
  logic [4:0] mCtrl;
  int         mPtr;
  bit         mHalt;

  always #(CLK_P/2) clk = ~clk;

  rtc_xact_monitor u0 (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType), .evByte(evByte),
    .evAck(evAck), .recValid(recValid), .recIsRead(recIsRead), .recSec(recSec),
    .recMin(recMin), .recHour(recHour), .recDay(recDay), .recMonth(recMonth),
    .recYear(recYear), .recFieldValid(recFieldValid), .recVoltLow(recVoltLow),
    .recCtrl(recCtrl)
  );

  function automatic logic [7:0] expBin(logic [7:0] b, logic [7:0] m);
    int v = int'(b & m);
    return 8'((v % 16) + 10 * (v / 16));
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendEv(int t, logic [7:0] b, logic a);
    @(negedge clk);
    evValid = 1; evType = 3'(t); evByte = b; evAck = a;
    @(negedge clk);
    evValid = 0;
  endtask

  task automatic mStart();
    for (int i = 0; i < 6; i++) mFld[i] = 8'hFF;
    mVld = 0; mVl = 0; mCtrl = 0; mPtr = 0; mHalt = 0;
  endtask

  task automatic mApply(logic [7:0] b, logic a);
    if (mHalt) return;
    case (mPtr)
      1: mCtrl = b[4:0];
      2: begin mFld[0] = expBin(b, 8'h7F); mVld[0] = 1; mVl = b[7]; end
      3: begin mFld[1] = expBin(b, 8'h7F); mVld[1] = 1; end
      4: begin mFld[2] = expBin(b, 8'h3F); mVld[2] = 1; end
      5: begin mFld[3] = expBin(b, 8'h3F); mVld[3] = 1; end
      7: begin mFld[4] = expBin(b, 8'h1F); mVld[4] = 1; end
      8: begin mFld[5] = expBin(b, 8'hFF); mVld[5] = 1; end
      default: ;
    endcase
    if (a) mPtr = (mPtr + 1) % 16;
    else   mHalt = 1;
  endtask

  task automatic checkRec(string req, logic isRead);
    check(req, "recValid", recValid, 1);
    check(req, "recIsRead", recIsRead, isRead);
    check(req, "sec", recSec, mFld[0]);
    check(req, "min", recMin, mFld[1]);
    check(req, "hour", recHour, mFld[2]);
    check(req, "day", recDay, mFld[3]);
    check(req, "month", recMonth, mFld[4]);
    check(req, "year", recYear, mFld[5]);
    check(req, "fieldValid", recFieldValid, mVld);
    check(req, "voltLow", recVoltLow, mVl);
    check(req, "ctrl", recCtrl, mCtrl);
    @(negedge clk);
    check("R4", "pulse end", recValid, 0);
  endtask

  task automatic openWr(logic [7:0] p);
    sendEv(0, 8'h00, 1); mStart();
    sendEv(2, 8'hA2, 1);
    sendEv(4, p, 1); mPtr = int'(p[3:0]);
  endtask

  initial begin
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "recValid", recValid, 0);
    check("R1", "fieldValid", recFieldValid, 0);
    check("R1", "sec", recSec, 8'hFF);
    check("R1", "year", recYear, 8'hFF);

    // R2 idle ignores non-start events
    sendEv(6, 8'h00, 1);
    check("R2", "no rec on idle stop", recValid, 0);
    sendEv(2, 8'hA2, 1); sendEv(4, 8'h02, 1); sendEv(4, 8'h45, 1);
    sendEv(6, 8'h00, 1);
    check("R2", "no rec without start", recValid, 0);
    check("R2", "sec untouched", recSec, 8'hFF);

    // R5 R6 R7 full write burst from register 0
    openWr(8'h00);
    begin
      logic [7:0] bytes [9] = '{8'h00, 8'h1F, 8'hD9, 8'h30, 8'h23, 8'h31, 8'h05, 8'h12, 8'h99};
      for (int i = 0; i < 9; i++) begin sendEv(4, bytes[i], 1); mApply(bytes[i], 1); end
    end
    sendEv(6, 8'h00, 1);
    check("R6", "seconds masked", recSec, 59);
    check("R6", "voltLow", recVoltLow, 1);
    check("R7", "ctrl flags", recCtrl, 5'h1F);
    check("R5", "year", recYear, 99);
    check("R5", "month", recMonth, 12);
    checkRec("R5", 0);

    // R11 R8 read path after repeated start
    openWr(8'h03);
    sendEv(1, 8'h00, 1);
    sendEv(3, 8'hA3, 1);
    sendEv(5, 8'h47, 1); mApply(8'h47, 1);
    sendEv(5, 8'h08, 0); mApply(8'h08, 0);
    sendEv(6, 8'h00, 1);
    check("R11", "read min", recMin, 47);
    check("R8", "partial mask", recFieldValid, 6'b000110);
    checkRec("R11", 1);

    // R9 pointer wrap and ignored registers
    openWr(8'h0F);
    sendEv(4, 8'hAA, 1); mApply(8'hAA, 1);
    sendEv(4, 8'h00, 1); mApply(8'h00, 1);
    sendEv(4, 8'h05, 1); mApply(8'h05, 1);
    sendEv(4, 8'h12, 1); mApply(8'h12, 1);
    sendEv(6, 8'h00, 1);
    check("R9", "wrap ctrl", recCtrl, 5'h05);
    check("R9", "wrap sec", recSec, 12);
    checkRec("R9", 0);

    // R10 NACK freezes the transaction
    openWr(8'h02);
    sendEv(4, 8'h10, 1); mApply(8'h10, 1);
    sendEv(4, 8'h20, 0); mApply(8'h20, 0);
    sendEv(4, 8'h11, 1); mApply(8'h11, 1);
    sendEv(6, 8'h00, 1);
    check("R10", "nacked byte kept", recMin, 20);
    check("R10", "later byte ignored", recFieldValid, 6'b000011);
    checkRec("R10", 0);

    // R3 wrong device address
    sendEv(0, 8'h00, 1);
    sendEv(2, 8'hA4, 1); sendEv(4, 8'h02, 1); sendEv(4, 8'h33, 1);
    sendEv(6, 8'h00, 1);
    check("R3", "no rec on foreign write addr", recValid, 0);
    openWr(8'h02);
    sendEv(1, 8'h00, 1); sendEv(3, 8'hA2, 1);
    sendEv(5, 8'h33, 1); sendEv(6, 8'h00, 1);
    check("R3", "no rec on foreign read addr", recValid, 0);

    // R11 wrong-direction data in write phase ignored
    openWr(8'h02);
    sendEv(5, 8'h44, 1);
    sendEv(4, 8'h15, 1); mApply(8'h15, 1);
    sendEv(6, 8'h00, 1);
    check("R11", "data read ignored in write phase", recMin, 8'hFF);
    checkRec("R11", 0);

    // random transactions against the model (R5 R9 R10 R11)
    for (int t = 0; t < 300; t++) begin
      bit rd = $urandom_range(0, 1);
      int n = $urandom_range(1, 10);
      openWr(8'($urandom_range(0, 15)));
      if (rd) begin sendEv(1, 8'h00, 1); sendEv(3, 8'hA3, 1); end
      for (int k = 0; k < n; k++) begin
        logic [7:0] b = 8'($urandom);
        logic a = ($urandom_range(0, 7) != 0);
        sendEv(rd ? 5 : 4, b, a); mApply(b, a);
      end
      sendEv(6, 8'h00, 1);
      checkRec(rd ? "R11" : "R5", rd);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule